// File: doc/BRIEF.md
# Endian-Selectable Bus Width Matcher

This block sits between a 36-bit long-word port and a second port whose width is set at configuration time. The second port can be a full 36-bit long word, an 18-bit word or a 9-bit byte. In the unpack direction, the block takes one long word and hands it out as one, two or four narrow pieces under a valid/ready handshake. In the pack direction, it collects narrow pieces and presents the finished long word for one cycle.

The bus-match and size inputs pick the narrow width and must stay static while the block runs. The byte order is captured from the endian input only while the synchronous master reset is high. In big-endian order the most significant lane moves first. In little-endian order the least significant lane moves first. The same order applies in both directions. The narrow port always carries 36 bits. In word and byte modes the piece sits in the low bits of that port.

Top module: `bus_width_matcher`

## Requirements
- R1: With cfgBusMatch low (long mode), each accepted long word leaves as one narrow transfer equal to it. Each narrow input produces a long output equal to it one cycle later.
- R2: With cfgBusMatch high and cfgSizeByte low (word mode), a long word takes two 18-bit transfers. Lane 0 is bits 17:0 and lane 1 is bits 35:18. Bits 35:18 of narrowOutData are zero, and bits 35:18 of narrowInData are ignored.
- R3: With cfgBusMatch high and cfgSizeByte high (byte mode), a long word takes four 9-bit transfers. Lane i is bits 9i+8:9i. Bits 35:9 of narrowOutData are zero, and bits 35:9 of narrowInData are ignored.
- R4: When cfgBigEndian is high during reset, pieces move from the highest lane down to lane 0 in both directions. Changing cfgBigEndian after reset has no effect.
- R5: When cfgBigEndian is low during reset, pieces move from lane 0 upward in both directions.
- R6: longInReady is low while any piece of the held word is untaken. It returns high in the cycle after the last piece is taken.
- R7: While narrowOutValid is high and narrowOutReady is low, narrowOutValid and narrowOutData hold steady.
- R8: In the pack direction, longOutValid is high for exactly the one cycle after the final piece arrives, and longOutData then holds the assembled word.
- R9: A synchronous reset clears the piece counters, the held word and any partly packed word. After reset, narrowOutValid and longOutValid are low and longInReady is high.
- R10: Cycles with narrowInValid low neither advance packing nor raise longOutValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| cfgBigEndian | input | 1 | Byte order, sampled only while rst is high |
| cfgBusMatch | input | 1 | High: narrow port is word or byte; low: long mode |
| cfgSizeByte | input | 1 | With cfgBusMatch high: high selects byte, low selects word |
| longInValid | input | 1 | Long word offered for unpacking |
| longInReady | output | 1 | Long word can be accepted |
| longInData | input | 36 | Long word to unpack |
| narrowOutValid | output | 1 | Narrow piece available |
| narrowOutReady | input | 1 | Consumer takes the narrow piece |
| narrowOutData | output | 36 | Narrow piece, in the low bits |
| narrowInValid | input | 1 | Narrow piece offered for packing |
| narrowInData | input | 36 | Narrow piece, in the low bits |
| longOutValid | output | 1 | One-cycle strobe for the assembled word |
| longOutData | output | 36 | Assembled long word |

## Verification
A long word that is accepted at a clock edge appears as piece 0 on the narrow port right after that edge. Each piece taken at an edge is replaced by the next one right after it. longInReady rises one edge after the final piece is taken. In the pack direction, the assembled word and its strobe are due one edge after the final piece is sampled, and the strobe drops at the edge after that. The bench drives and samples on the falling edge, and it counts every rising edge between a stimulus and its check. This puts each comparison in exactly the cycle where the result is due, including cycles where random back-pressure or input gaps stretch the sequence.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  typedef enum logic [1:0] {
    MODE_LONG = 2'd0,
    MODE_WORD = 2'd1,
    MODE_BYTE = 2'd2
  } widthMode_e;

  // strobes from control to datapath
  typedef struct packed {
    widthMode_e mode;
    logic       loadHold;
    logic [1:0] outLane;
    logic       packWrite;
    logic [1:0] inLane;
  } dpStrobe_t;

endpackage

// File: rtl/bwm_ctrl.sv
module bwm_ctrl
  import bwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfgBigEndian,
  input  logic      cfgBusMatch,
  input  logic      cfgSizeByte,
  input  logic      longInValid,
  output logic      longInReady,
  output logic      narrowOutValid,
  input  logic      narrowOutReady,
  input  logic      narrowInValid,
  output logic      longOutValid,
  output dpStrobe_t strobe
);

  widthMode_e mode;
  logic [1:0] lastIdx;
  logic       bigQ;
  logic       holdValid;
  logic [1:0] outCnt;
  logic [1:0] inCnt;
  logic       packDone;
  logic       accept;
  logic       take;

  always_comb begin
    if (!cfgBusMatch)     mode = MODE_LONG;
    else if (cfgSizeByte) mode = MODE_BYTE;
    else                  mode = MODE_WORD;
    case (mode)
      MODE_WORD: lastIdx = 2'd1;
      MODE_BYTE: lastIdx = 2'd3;
      default:   lastIdx = 2'd0;
    endcase
  end

  assign accept = longInValid && !holdValid;
  assign take   = holdValid && narrowOutReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      bigQ      <= cfgBigEndian;
      holdValid <= 1'b0;
      outCnt    <= '0;
      inCnt     <= '0;
      packDone  <= 1'b0;
    end else begin
      if (accept)
        holdValid <= 1'b1;
      else if (take && outCnt == lastIdx)
        holdValid <= 1'b0;
      if (take)
        outCnt <= (outCnt == lastIdx) ? 2'd0 : outCnt + 2'd1;
      if (narrowInValid)
        inCnt <= (inCnt == lastIdx) ? 2'd0 : inCnt + 2'd1;
      packDone <= narrowInValid && (inCnt == lastIdx);
    end
  end

  assign longInReady    = !holdValid;
  assign narrowOutValid = holdValid;
  assign longOutValid   = packDone;

  always_comb begin
    strobe.mode      = mode;
    strobe.loadHold  = accept;
    strobe.outLane   = bigQ ? lastIdx - outCnt : outCnt;
    strobe.packWrite = narrowInValid;
    strobe.inLane    = bigQ ? lastIdx - inCnt : inCnt;
  end

endmodule

// File: rtl/bwm_datapath.sv
module bwm_datapath
  import bwm_pkg::*;
#(
  parameter int LONG_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [LONG_W-1:0] longInData,
  input  logic [LONG_W-1:0] narrowInData,
  output logic [LONG_W-1:0] narrowOutData,
  output logic [LONG_W-1:0] longOutData
);

  localparam int BYTE_LANES = 4;
  localparam int WORD_LANES = 2;
  localparam int BYTE_W     = LONG_W / BYTE_LANES;
  localparam int WORD_W     = LONG_W / WORD_LANES;

  logic [LONG_W-1:0] holdData;
  logic [LONG_W-1:0] packReg;
  logic [BYTE_W-1:0] byteLane [BYTE_LANES];
  logic [WORD_W-1:0] wordLane [WORD_LANES];

  for (genvar g = 0; g < BYTE_LANES; g++) begin : gByte
    assign byteLane[g] = holdData[g*BYTE_W +: BYTE_W];
  end
  for (genvar g = 0; g < WORD_LANES; g++) begin : gWord
    assign wordLane[g] = holdData[g*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdData <= '0;
      packReg  <= '0;
    end else begin
      if (strobe.loadHold)
        holdData <= longInData;
      if (strobe.packWrite) begin
        case (strobe.mode)
          MODE_WORD: packReg[int'(strobe.inLane[0])*WORD_W +: WORD_W] <= narrowInData[WORD_W-1:0];
          MODE_BYTE: packReg[int'(strobe.inLane)*BYTE_W +: BYTE_W]    <= narrowInData[BYTE_W-1:0];
          default:   packReg <= narrowInData;
        endcase
      end
    end
  end

  always_comb begin
    narrowOutData = '0;
    case (strobe.mode)
      MODE_WORD: narrowOutData[WORD_W-1:0] = wordLane[strobe.outLane[0]];
      MODE_BYTE: narrowOutData[BYTE_W-1:0] = byteLane[strobe.outLane];
      default:   narrowOutData = holdData;
    endcase
  end

  assign longOutData = packReg;

endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
  import bwm_pkg::*;
#(
  parameter int LONG_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgBigEndian,
  input  logic              cfgBusMatch,
  input  logic              cfgSizeByte,
  input  logic              longInValid,
  output logic              longInReady,
  input  logic [LONG_W-1:0] longInData,
  output logic              narrowOutValid,
  input  logic              narrowOutReady,
  output logic [LONG_W-1:0] narrowOutData,
  input  logic              narrowInValid,
  input  logic [LONG_W-1:0] narrowInData,
  output logic              longOutValid,
  output logic [LONG_W-1:0] longOutData
);

  dpStrobe_t strobe;

  bwm_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .cfgBigEndian   (cfgBigEndian),
    .cfgBusMatch    (cfgBusMatch),
    .cfgSizeByte    (cfgSizeByte),
    .longInValid    (longInValid),
    .longInReady    (longInReady),
    .narrowOutValid (narrowOutValid),
    .narrowOutReady (narrowOutReady),
    .narrowInValid  (narrowInValid),
    .longOutValid   (longOutValid),
    .strobe         (strobe)
  );

  bwm_datapath #(.LONG_W(LONG_W)) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .longInData    (longInData),
    .narrowInData  (narrowInData),
    .narrowOutData (narrowOutData),
    .longOutData   (longOutData)
  );

endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
  parameter int LONG_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cfgBusMatch,
  input logic              cfgSizeByte,
  input logic              longInReady,
  input logic              narrowOutValid,
  input logic              narrowOutReady,
  input logic [LONG_W-1:0] narrowOutData,
  input logic              longOutValid
);

  localparam int BYTE_W = LONG_W / 4;
  localparam int WORD_W = LONG_W / 2;

  // R6: ready only comes back after a piece was taken
  a_r6_ready_after_take: assert property (@(posedge clk) disable iff (rst)
    $rose(longInReady) |-> $past(narrowOutValid && narrowOutReady));

  // R7: a stalled piece holds
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (narrowOutValid && !narrowOutReady) |=> (narrowOutValid && $stable(narrowOutData)));

  // R8: pack strobe lasts one cycle when serializing
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (cfgBusMatch && longOutValid) |=> !longOutValid);

  // R2: word mode upper bits zero
  a_r2_word_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (narrowOutValid && cfgBusMatch && !cfgSizeByte) |-> (narrowOutData[LONG_W-1:WORD_W] == '0));

  // R3: byte mode upper bits zero
  a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (narrowOutValid && cfgBusMatch && cfgSizeByte) |-> (narrowOutData[LONG_W-1:BYTE_W] == '0));

  // R9: state after reset
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!narrowOutValid && !longOutValid && longInReady));

endmodule

bind bus_width_matcher bwm_checker #(.LONG_W(LONG_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfgBusMatch    (cfgBusMatch),
  .cfgSizeByte    (cfgSizeByte),
  .longInReady    (longInReady),
  .narrowOutValid (narrowOutValid),
  .narrowOutReady (narrowOutReady),
  .narrowOutData  (narrowOutData),
  .longOutValid   (longOutValid)
);

// File: tb/tb_bus_width_matcher.sv
module tb_bus_width_matcher;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgBigEndian = 1'b0;
  logic        cfgBusMatch = 1'b0;
  logic        cfgSizeByte = 1'b0;
  logic        longInValid = 1'b0;
  logic        longInReady;
  logic [35:0] longInData = '0;
  logic        narrowOutValid;
  logic        narrowOutReady = 1'b0;
  logic [35:0] narrowOutData;
  logic        narrowInValid = 1'b0;
  logic [35:0] narrowInData = '0;
  logic        longOutValid;
  logic [35:0] longOutData;

  int total = 0;
  int failed = 0;

  always #5 clk = ~clk;

  bus_width_matcher dut (
    .clk(clk), .rst(rst), .cfgBigEndian(cfgBigEndian), .cfgBusMatch(cfgBusMatch),
    .cfgSizeByte(cfgSizeByte), .longInValid(longInValid), .longInReady(longInReady),
    .longInData(longInData), .narrowOutValid(narrowOutValid), .narrowOutReady(narrowOutReady),
    .narrowOutData(narrowOutData), .narrowInValid(narrowInValid), .narrowInData(narrowInData),
    .longOutValid(longOutValid), .longOutData(longOutData)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int piecesOf(input logic bm, input logic sz);
    return !bm ? 1 : (sz ? 4 : 2);
  endfunction

  // software reorder model
  function automatic logic [35:0] pieceOf(input logic [35:0] w, input int k,
                                          input logic bm, input logic sz, input logic big);
    int n = piecesOf(bm, sz);
    int pw = 36 / n;
    int lane = big ? n - 1 - k : k;
    logic [35:0] mask = (n == 1) ? {36{1'b1}} : ((36'd1 << pw) - 36'd1);
    return (w >> (lane * pw)) & mask;
  endfunction

  function automatic logic [35:0] rnd36();
    return {$urandom(), $urandom()};
  endfunction

  task automatic doReset(input logic big);
    @(negedge clk);
    rst = 1'b1;
    cfgBigEndian = big;
    longInValid = 1'b0;
    narrowInValid = 1'b0;
    narrowOutReady = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cfgBigEndian = !big;  // R4: later changes must not matter
    @(negedge clk);
    check("R9 narrowOutValid", {35'd0, narrowOutValid}, 36'd0);
    check("R9 longOutValid", {35'd0, longOutValid}, 36'd0);
    check("R9 longInReady", {35'd0, longInReady}, 36'd1);
    check("R9 longOutData", longOutData, 36'd0);
  endtask

  task automatic unpackWord(input logic [35:0] w, input logic big, input string req);
    int n = piecesOf(cfgBusMatch, cfgSizeByte);
    int k = 0;
    check("R6 ready before word", {35'd0, longInReady}, 36'd1);
    longInValid = 1'b1;
    longInData = w;
    @(negedge clk);
    longInValid = 1'b0;
    longInData = rnd36();
    while (k < n) begin
      logic rdy = ($urandom() % 3) != 0;
      narrowOutReady = rdy;
      check({req, " piece valid"}, {35'd0, narrowOutValid}, 36'd1);
      check({req, " piece data"}, narrowOutData, pieceOf(w, k, cfgBusMatch, cfgSizeByte, big));
      check("R6 ready low while held", {35'd0, longInReady}, 36'd0);
      @(negedge clk);
      if (rdy) k++;
    end
    narrowOutReady = 1'b0;
    check("R6 ready back", {35'd0, longInReady}, 36'd1);
    check("R6 nothing pending", {35'd0, narrowOutValid}, 36'd0);
  endtask

  task automatic packWord(input logic [35:0] w, input logic big, input string req);
    int n = piecesOf(cfgBusMatch, cfgSizeByte);
    int pw = 36 / n;
    int k = 0;
    while (k < n) begin
      logic gap = ($urandom() % 3) == 0;
      logic [35:0] junk = rnd36();
      narrowInValid = !gap;
      if (n == 1) narrowInData = w;
      else narrowInData = (junk << pw) | pieceOf(w, k, cfgBusMatch, cfgSizeByte, big);
      @(negedge clk);
      if (!gap) k++;
      if (k < n) check("R10 no early strobe", {35'd0, longOutValid}, 36'd0);
    end
    narrowInValid = 1'b0;
    check("R8 strobe", {35'd0, longOutValid}, 36'd1);
    check({req, " packed word"}, longOutData, w);
    @(negedge clk);
    check("R8 strobe drops", {35'd0, longOutValid}, 36'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failed++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    for (int cfg = 0; cfg < 6; cfg++) begin
      logic big = cfg[0];
      string req;
      cfgBusMatch = (cfg >= 2);
      cfgSizeByte = (cfg >= 4);
      if (!cfgBusMatch) req = "R1";
      else if (cfgSizeByte) req = big ? "R3/R4" : "R3/R5";
      else req = big ? "R2/R4" : "R2/R5";
      doReset(big);
      for (int i = 0; i < 12; i++) unpackWord(rnd36(), big, req);
      unpackWord(36'hFFFFFFFFF, big, req);
      unpackWord(36'h123456789, big, req);
      for (int i = 0; i < 12; i++) packWord(rnd36(), big, req);
      packWord(36'h000000000, big, req);
      packWord(36'h987654321, big, req);
    end

    // R9: partial pack and partial unpack abandoned by reset
    cfgBusMatch = 1'b1;
    cfgSizeByte = 1'b1;
    doReset(1'b0);
    @(negedge clk);
    narrowInValid = 1'b1;
    narrowInData = 36'h0AA;
    repeat (2) @(negedge clk);
    narrowInValid = 1'b0;
    longInValid = 1'b1;
    longInData = 36'hABCDEF012;
    @(negedge clk);
    longInValid = 1'b0;
    narrowOutReady = 1'b1;
    @(negedge clk);
    narrowOutReady = 1'b0;
    doReset(1'b0);
    packWord(36'h13579BDF0, 1'b0, "R9");
    unpackWord(36'h2468ACE13, 1'b0, "R9");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule